// File: doc/BRIEF.md
# Strided Vector Address Generator with Strip Mining

This block turns a single vector memory request into a stream of word addresses, one per clock. A request gives a byte base address, a signed element stride and an application length `n`. Elements are 64-bit words, so a stride of `s` moves the byte address by `8*s` from one element to the next. A stride of 1 walks contiguous memory, and a negative stride walks backwards.

Requests longer than the maximum vector length (64) are split into strips. The odd-sized piece (`n mod 64` elements) is issued first, and every strip after it holds a full 64 elements. If `n` is an exact multiple of 64, there is no short strip at all. For every address the block also shows the length of the strip it belongs to, which is the value a vector length register would hold. It flags the first and last element of each strip and of the whole request.

A valid/ready pair on the address side lets the memory stall the stream. When the last address has been accepted, a one-cycle done pulse follows.

Top module: `strided_agen`

## Requirements
- R1: After reset, `busy_o`, `addr_valid_o` and `done_o` are all low.
- R2: A start with nonzero `total_i` is taken while idle. In the next cycle `addr_valid_o` is high and `addr_o` equals `base_i`.
- R3: Each accepted address is followed by one that is greater by `stride_i*8`, taken modulo 2^32. The stride is signed. This holds across strip boundaries too, so each strip begins at the previous strip's start plus its length times the byte stride.
- R4: When `n mod 64` is nonzero, the first strip has exactly that many elements. `vlen_o` shows that length for each of its elements.
- R5: Every strip after the first has 64 elements. When `n mod 64` is zero, all strips have 64 elements and no empty strip is produced.
- R6: `strip_first_o` and `strip_last_o` are high on the first and last element of each strip. `req_first_o` and `req_last_o` are high on the first and last element of the request.
- R7: While `addr_valid_o` is high and `addr_ready_i` is low, the address, the length and every flag hold, and valid stays high.
- R8: `done_o` is high for exactly one cycle: the cycle after the last address is accepted. `busy_o` is low in that cycle.
- R9: A start that arrives while busy is ignored. The running request continues unchanged.
- R10: A start with `total_i` equal to 0 issues no addresses and raises `done_o` in the next cycle.
- R11: Exactly `n` addresses are issued per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request start, taken only when idle |
| base_i | input | 32 | Byte address of element 0 |
| stride_i | input | 16 | Signed element stride |
| total_i | input | 16 | Application length n in elements |
| busy_o | output | 1 | A request is in progress |
| addr_valid_o | output | 1 | `addr_o` holds an address to issue |
| addr_ready_i | input | 1 | Memory accepts the address this cycle |
| addr_o | output | 32 | Element byte address |
| vlen_o | output | 7 | Length of the current strip |
| strip_first_o | output | 1 | First element of a strip |
| strip_last_o | output | 1 | Last element of a strip |
| req_first_o | output | 1 | First element of the request |
| req_last_o | output | 1 | Last element of the request |
| done_o | output | 1 | One-cycle pulse after the final acceptance |

## Verification
The bench uses lengths of 1, 5 and 70, where the remainder strip comes first, and lengths of 64 and 128, where no short strip may appear. A design that issued an empty strip or placed the remainder last would show the wrong `vlen_o` or misplaced strip flags. Negative and zero strides, and a base near the top of the address space, check that the signed step is carried across strip boundaries and wraps correctly. A wrong strip start would break the address sequence at element 64 or 65. Random back-pressure tests that a stalled address never moves, and a start injected mid-request checks that a busy block does not reload. A zero-length start checks that done arrives with no addresses at all.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int unsigned AG_ADDR_W     = 32;
    localparam int unsigned AG_N_W        = 16;
    localparam int unsigned AG_STRIDE_W   = 16;
    localparam int unsigned AG_MAXVL      = 64;
    localparam int unsigned AG_ELEM_BYTES = 8;

    typedef enum logic {
        AG_IDLE = 1'b0,
        AG_RUN  = 1'b1
    } ag_state_e;

    typedef struct packed {
        logic strip_first;
        logic strip_last;
        logic req_first;
        logic req_last;
    } ag_tag_t;

    // Length of the strip that opens a request of n elements (n > 0).
    function automatic int unsigned head_len(input int unsigned n, input int unsigned mvl);
        int unsigned r;
        r = n % mvl;
        return (r == 0) ? mvl : r;
    endfunction

    // Number of full strips that follow the opening strip (n > 0).
    function automatic int unsigned tail_strips(input int unsigned n, input int unsigned mvl);
        if (n == 0) return 0;
        return ((n % mvl) == 0) ? (n / mvl) - 1 : (n / mvl);
    endfunction

endpackage

// File: rtl/agen_strip_ctl.sv
module agen_strip_ctl
    import agen_pkg::*;
#(
    parameter int unsigned N_W   = AG_N_W,
    parameter int unsigned MAXVL = AG_MAXVL,
    parameter int unsigned VL_W  = $clog2(MAXVL + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [N_W-1:0]  n_i,
    input  logic            adv_i,
    output logic [VL_W-1:0] vlen_o,
    output logic            strip_first_o,
    output logic            strip_last_o,
    output logic            final_o
);

    logic [VL_W-1:0] idx_q;
    logic [VL_W-1:0] len_q;
    logic [N_W-1:0]  left_q;

    assign vlen_o        = len_q;
    assign strip_first_o = (idx_q == '0);
    assign strip_last_o  = (idx_q == len_q - VL_W'(1));
    assign final_o       = strip_last_o && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            len_q  <= VL_W'(1);
            left_q <= '0;
        end else if (load_i) begin
            idx_q  <= '0;
            len_q  <= VL_W'(head_len(32'(n_i), MAXVL));
            left_q <= N_W'(tail_strips(32'(n_i), MAXVL));
        end else if (adv_i) begin
            if (strip_last_o) begin
                if (left_q != '0) begin
                    idx_q  <= '0;
                    len_q  <= VL_W'(MAXVL);
                    left_q <= left_q - N_W'(1);
                end
            end else begin
                idx_q <= idx_q + VL_W'(1);
            end
        end
    end

    // R4
    idx_in_strip_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q < len_q);

    // R5
    refill_full_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && strip_last_o && left_q != '0) |=> (vlen_o == VL_W'(MAXVL)) && strip_first_o);

endmodule

// File: rtl/agen_addr_step.sv
module agen_addr_step
    import agen_pkg::*;
#(
    parameter int unsigned ADDR_W     = AG_ADDR_W,
    parameter int unsigned STRIDE_W   = AG_STRIDE_W,
    parameter int unsigned ELEM_BYTES = AG_ELEM_BYTES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_i,
    input  logic [ADDR_W-1:0]          base_i,
    input  logic signed [STRIDE_W-1:0] stride_i,
    input  logic                       adv_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [ADDR_W-1:0]          step_o
);

    localparam bit          IS_POW2 = ((ELEM_BYTES & (ELEM_BYTES - 1)) == 0);
    localparam int unsigned SHIFT   = $clog2(ELEM_BYTES);

    logic signed [ADDR_W-1:0] stride_ext;
    logic [ADDR_W-1:0]        step_d;
    logic [ADDR_W-1:0]        addr_q;
    logic [ADDR_W-1:0]        step_q;

    assign stride_ext = ADDR_W'(stride_i);

    generate
        if (IS_POW2) begin : g_shift
            assign step_d = ADDR_W'(stride_ext) << SHIFT;
        end else begin : g_mul
            assign step_d = ADDR_W'(stride_ext) * ADDR_W'(ELEM_BYTES);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            step_q <= '0;
        end else if (load_i) begin
            addr_q <= base_i;
            step_q <= step_d;
        end else if (adv_i) begin
            addr_q <= addr_q + step_q;
        end
    end

    assign addr_o = addr_q;
    assign step_o = step_q;

    // R2
    load_base_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(base_i)));

endmodule

// File: rtl/strided_agen.sv
module strided_agen
    import agen_pkg::*;
#(
    parameter int unsigned ADDR_W     = AG_ADDR_W,
    parameter int unsigned N_W        = AG_N_W,
    parameter int unsigned STRIDE_W   = AG_STRIDE_W,
    parameter int unsigned MAXVL      = AG_MAXVL,
    parameter int unsigned ELEM_BYTES = AG_ELEM_BYTES,
    parameter int unsigned VL_W       = $clog2(MAXVL + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [ADDR_W-1:0]          base_i,
    input  logic signed [STRIDE_W-1:0] stride_i,
    input  logic [N_W-1:0]             total_i,
    output logic                       busy_o,
    output logic                       addr_valid_o,
    input  logic                       addr_ready_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [VL_W-1:0]            vlen_o,
    output logic                       strip_first_o,
    output logic                       strip_last_o,
    output logic                       req_first_o,
    output logic                       req_last_o,
    output logic                       done_o
);

    ag_state_e        state_q;
    logic             done_q;
    logic             head_q;
    logic             take;
    logic             load;
    logic             accept;
    logic             s_first;
    logic             s_last;
    logic             s_final;
    logic [ADDR_W-1:0] step;
    ag_tag_t          tag;

    assign take   = (state_q == AG_IDLE) && start_i;
    assign load   = take && (total_i != '0);
    assign accept = (state_q == AG_RUN) && addr_ready_i;

    agen_strip_ctl #(
        .N_W   (N_W),
        .MAXVL (MAXVL),
        .VL_W  (VL_W)
    ) u_strip (
        .clk           (clk),
        .rst           (rst),
        .load_i        (load),
        .n_i           (total_i),
        .adv_i         (accept),
        .vlen_o        (vlen_o),
        .strip_first_o (s_first),
        .strip_last_o  (s_last),
        .final_o       (s_final)
    );

    agen_addr_step #(
        .ADDR_W     (ADDR_W),
        .STRIDE_W   (STRIDE_W),
        .ELEM_BYTES (ELEM_BYTES)
    ) u_step (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .base_i   (base_i),
        .stride_i (stride_i),
        .adv_i    (accept),
        .addr_o   (addr_o),
        .step_o   (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= AG_IDLE;
            done_q  <= 1'b0;
            head_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                if (total_i != '0) begin
                    state_q <= AG_RUN;
                    head_q  <= 1'b1;
                end else begin
                    done_q <= 1'b1;
                end
            end else if (accept) begin
                head_q <= 1'b0;
                if (s_final) begin
                    state_q <= AG_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        tag.strip_first = s_first;
        tag.strip_last  = s_last;
        tag.req_first   = head_q;
        tag.req_last    = s_final;
    end

    assign busy_o        = (state_q == AG_RUN);
    assign addr_valid_o  = (state_q == AG_RUN);
    assign strip_first_o = tag.strip_first;
    assign strip_last_o  = tag.strip_last;
    assign req_first_o   = tag.req_first;
    assign req_last_o    = tag.req_last;
    assign done_o        = done_q;

    // Checker state: start address and length of the strip most recently begun
    logic [ADDR_W-1:0] chk_start_q;
    logic [VL_W-1:0]   chk_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_start_q <= '0;
            chk_len_q   <= '0;
        end else if (accept && s_first) begin
            chk_start_q <= addr_o;
            chk_len_q   <= vlen_o;
        end
    end

    // R3
    strip_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_o && strip_first_o && !req_first_o)
            |-> (addr_o == chk_start_q + ADDR_W'(chk_len_q) * step));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_o && !addr_ready_i)
            |=> (addr_valid_o && $stable(addr_o) && $stable(vlen_o) && $stable(tag)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !(accept && req_last_o)) |=> busy_o);

    // R5
    later_full_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_o && strip_first_o && !req_first_o) |-> (vlen_o == VL_W'(MAXVL)));

endmodule

// File: tb/strided_agen_test.sv
`timescale 1ns/1ps
module strided_agen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic signed [15:0] stride_i = '0;
    logic [15:0] total_i = '0;
    logic        busy_o, addr_valid_o, addr_ready_i;
    logic [31:0] addr_o;
    logic [6:0]  vlen_o;
    logic        strip_first_o, strip_last_o, req_first_o, req_last_o, done_o;

    always #2.5 clk = ~clk;

    strided_agen uut (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
        .stride_i(stride_i), .total_i(total_i), .busy_o(busy_o),
        .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
        .addr_o(addr_o), .vlen_o(vlen_o), .strip_first_o(strip_first_o),
        .strip_last_o(strip_last_o), .req_first_o(req_first_o),
        .req_last_o(req_last_o), .done_o(done_o)
    );

    typedef struct {
        logic [31:0] a;
        logic [6:0]  vl;
        logic [3:0]  tg;   // {strip_first, strip_last, req_first, req_last}
    } exp_t;

    exp_t expq[$];
    int   total = 0;
    int   bad = 0;
    int   done_count = 0;
    bit   exp_done = 0;
    bit   allow_done = 0;
    bit   stall_mode = 0;
    bit   was_stall = 0;
    logic [31:0] prev_a;
    logic [6:0]  prev_vl;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Ready driver: changes only just after a rising edge
    always @(posedge clk) begin
        #1;
        addr_ready_i = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end

    // Monitor and scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                done_count++;
                chk(exp_done || allow_done, "R8", "unexpected done", 64'(done_o), 64'd0);
                if (exp_done) chk(!busy_o, "R8", "busy during done", 64'(busy_o), 64'd0);
            end else if (exp_done) begin
                chk(1'b0, "R8", "done missing", 64'(done_o), 64'd1);
            end
            exp_done = 0;
            if (was_stall)
                chk(addr_valid_o && addr_o == prev_a && vlen_o == prev_vl, "R7",
                    "stalled address moved", 64'(addr_o), 64'(prev_a));
            if (addr_valid_o && addr_ready_i) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R11", "extra address", 64'(addr_o), 64'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(addr_o == e.a, "R3", "address", 64'(addr_o), 64'(e.a));
                    chk(vlen_o == e.vl, "R4", "strip length", 64'(vlen_o), 64'(e.vl));
                    chk({strip_first_o, strip_last_o, req_first_o, req_last_o} == e.tg, "R6",
                        "flags", 64'({strip_first_o, strip_last_o, req_first_o, req_last_o}),
                        64'(e.tg));
                    if (e.tg[0]) exp_done = 1;
                end
            end
            was_stall = addr_valid_o && !addr_ready_i;
            prev_a    = addr_o;
            prev_vl   = vlen_o;
        end
    end

    task automatic run_req(input logic [31:0] base, input int stride, input int n,
                           input bit stall, input bit poke);
        int lens[$];
        int k = 0;
        int d0;
        if ((n % 64) != 0) lens.push_back(n % 64);
        for (int s = 0; s < n / 64; s++) lens.push_back(64);
        foreach (lens[s]) begin
            for (int e = 0; e < lens[s]; e++) begin
                exp_t it;
                it.a  = base + 32'(longint'(k) * longint'(stride) * 64'sd8);
                it.vl = 7'(lens[s]);
                it.tg = {e == 0, e == lens[s] - 1, k == 0, k == n - 1};
                expq.push_back(it);
                k++;
            end
        end
        stall_mode = stall;
        d0 = done_count;
        @(posedge clk); #1;
        base_i = base; stride_i = 16'(stride); total_i = 16'(n); start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        chk(addr_valid_o && busy_o, "R2", "valid after start", 64'(addr_valid_o), 64'd1);
        if (poke) begin
            repeat (3) @(posedge clk);
            #1;
            base_i = 32'hDEAD0000; total_i = 16'd7; stride_i = 16'sd3; start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        while (done_count == d0) @(posedge clk);
        @(negedge clk);
        chk(expq.size() == 0, "R11", "addresses left over", 64'(expq.size()), 64'd0);
        chk(!busy_o && !addr_valid_o, "R9", "busy after done", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        addr_ready_i = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o, "R1", "busy", 64'(busy_o), 64'd0);
        chk(!addr_valid_o, "R1", "valid", 64'(addr_valid_o), 64'd0);
        chk(!done_o, "R1", "done", 64'(done_o), 64'd0);

        run_req(32'h0000_1000, 1, 5, 0, 0);      // R4 short single strip
        run_req(32'h0000_2000, 1, 64, 0, 0);     // R5 exact multiple, no empty strip
        run_req(32'h0000_8000, -3, 130, 1, 0);   // R3 R4 R5 negative stride, stalls
        run_req(32'hFFFF_FF00, 2, 70, 1, 0);     // R3 wrap across the top
        run_req(32'h0000_0040, 0, 1, 0, 0);      // R6 one element: all flags
        run_req(32'h0000_0100, -1, 128, 0, 0);   // R5 two full strips

        // R10 zero length
        allow_done = 1;
        @(posedge clk); #1;
        total_i = 16'd0; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        chk(done_o, "R10", "done after empty start", 64'(done_o), 64'd1);
        chk(!addr_valid_o, "R10", "no address", 64'(addr_valid_o), 64'd0);
        @(posedge clk); #1;
        allow_done = 0;

        run_req(32'h0000_3000, 5, 200, 1, 1);    // R9 start while busy ignored
        run_req(32'h0001_0000, 7, 65, 1, 0);     // R4 one-element head strip

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule